// File: doc/BRIEF.md
# Line Buffer Configuration Selector

This block picks the line-buffer memory arrangement for a vertical scaling filter. It takes the luma and chroma line widths, the stored component depth, an alpha-plane flag, a 4:2:0 flag, and for each plane the vertical tap count and the ceiling of the vertical scale ratio. From these it works out how many whole lines (partitions) each candidate arrangement can hold. It then returns the first arrangement in a fixed trial order whose luma and chroma partitions are enough for the filter.

A run begins with a one-cycle `start` pulse, which captures all inputs. Every division is done by one shared iterative restoring divider, so a run takes a few hundred cycles. The end of a run is marked by a one-cycle `done` pulse. The chosen arrangement index and both partition counts stay on the outputs until the next run ends.

Top module: `lb_cfg_select`

## Requirements
- R1: Words per line are ceil(w·b/72) for luma and for chroma, and ceil(w/6) for alpha, where w is the line width and b is the component depth. `bpc_sel` encodes the depth as 0=10, 1=8, 2=6 and 3=12 bits. A width of 0 is treated as 1.
- R2: Each partition count is the arrangement's word count for that plane divided by the words per line, rounded down, and then clamped to 64. The word counts are: arrangement 1 = 816 luma, 816 chroma, 984 alpha; arrangement 2 = 1088, 1088, 1312; arrangement 3 = 4448, 1904, 2752; arrangement 0 = 2752 luma, 2752 chroma, 2752 alpha.
- R3: When `alpha_en` is 1, the luma partition count is lowered to the alpha partition count if the alpha count is smaller.
- R4: Let r be the ratio ceiling and t the tap count. A plane fits when t ≤ partitions for r ≤ 2, and when t ≤ partitions − r + 2 for r > 2. An arrangement is accepted only if both planes fit.
- R5: Arrangements are tried in the order 1, 2, 3, 0. Arrangement 3 is tried only when `is_420` is 1. Arrangement 0 is returned when nothing earlier fits.
- R6: When `force_max` is 1, no search is made. The result is arrangement 3 if `is_420` is 1 and arrangement 0 otherwise, with that arrangement's partition counts.
- R7: `done` is a single-cycle pulse once per accepted start. A `start` that arrives while a run is in progress is ignored. The outputs hold their values between runs.
- R8: After reset, `done`, `cfg` and both partition outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search; captures all inputs |
| width_y | input | WIDTH_W | Luma line width in pixels |
| width_c | input | WIDTH_W | Chroma line width in pixels |
| bpc_sel | input | 2 | Component depth code |
| alpha_en | input | 1 | Alpha plane present |
| is_420 | input | 1 | 4:2:0 format |
| force_max | input | 1 | Skip the search and return the largest arrangement |
| vtaps_y | input | TAP_W | Luma vertical taps |
| vtaps_c | input | TAP_W | Chroma vertical taps |
| vratio_y | input | RATIO_W | Ceiling of luma vertical ratio |
| vratio_c | input | RATIO_W | Ceiling of chroma vertical ratio |
| done | output | 1 | Result valid pulse |
| cfg | output | 2 | Chosen arrangement index |
| parts_y | output | PART_W | Luma partitions |
| parts_c | output | PART_W | Chroma partitions |

## Verification
The hardest outcome to reach is the fall-through to arrangement 3 or arrangement 0. Getting there needs a line wide enough that neither small arrangement can hold the requested taps, while the large arrangement still can. The stimulus uses very wide 12-bit lines, with and without the 4:2:0 flag, so that the two branches of the fallback can be compared. A further case uses a ratio ceiling above 2, which pushes the 1920-pixel case past arrangement 2. A narrow line with alpha enabled makes the alpha limit the deciding factor below the clamp.

// File: rtl/lbsel_pkg.sv
package lbsel_pkg;
  localparam int BANK_A   = 816;
  localparam int BANK_B   = 1088;
  localparam int BANK_C   = 848;
  localparam int ABANK_A  = 984;
  localparam int ABANK_B  = 1312;
  localparam int ABANK_C  = 456;
  localparam int WORD_BITS = 72;
  localparam int ALPHA_PIX = 6;

  typedef enum logic [1:0] {PL_Y, PL_C, PL_A} plane_t;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_EVAL} state_t;

  function automatic int bpc_bits(input logic [1:0] sel);
    case (sel)
      2'd0: return 10;
      2'd1: return 8;
      2'd2: return 6;
      default: return 12;
    endcase
  endfunction

  function automatic int mem_words(input logic [1:0] cfg, input plane_t pl);
    if (pl == PL_A) begin
      case (cfg)
        2'd1: return ABANK_A;
        2'd2: return ABANK_B;
        default: return ABANK_A + ABANK_B + ABANK_C;
      endcase
    end
    case (cfg)
      2'd1: return BANK_A;
      2'd2: return BANK_B;
      2'd3: return (pl == PL_Y) ? BANK_A + BANK_B + 3 * BANK_C : BANK_A + BANK_B;
      default: return BANK_A + BANK_B + BANK_C;
    endcase
  endfunction
endpackage

// File: rtl/lbsel_div.sv
module lbsel_div #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [DW-1:0] quo
);
  localparam int CW = $clog2(DW + 1);

  logic [DW:0]   rem;
  logic [DW:0]   rem_sh;
  logic [CW-1:0] cnt;
  logic [DW-1:0] num_q, den_q;

  assign rem_sh = {rem[DW-1:0], quo[DW-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0; quo <= '0; cnt <= '0; done <= 1'b0;
      num_q <= '0; den_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem <= '0; quo <= num; cnt <= CW'(DW);
        num_q <= num; den_q <= den;
      end else if (cnt != '0) begin
        if (rem_sh >= {1'b0, den_q}) begin
          rem <= rem_sh - {1'b0, den_q};
          quo <= {quo[DW-2:0], 1'b1};
        end else begin
          rem <= rem_sh;
          quo <= {quo[DW-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) done <= 1'b1;
      end
    end
  end

  // Quotient must bracket the captured dividend (supports R2).
  assert_quotient_exact_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> ((2*DW)'(quo) * (2*DW)'(den_q) <= (2*DW)'(num_q)) &&
             ((2*DW)'(num_q) < ((2*DW)'(quo) + 1) * (2*DW)'(den_q)));
endmodule

// File: rtl/lb_cfg_select.sv
module lb_cfg_select
  import lbsel_pkg::*;
#(
  parameter int WIDTH_W   = 14,
  parameter int TAP_W     = 4,
  parameter int RATIO_W   = 4,
  parameter int MAX_PARTS = 64,
  parameter int PART_W    = $clog2(MAX_PARTS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WIDTH_W-1:0] width_y,
  input  logic [WIDTH_W-1:0] width_c,
  input  logic [1:0]         bpc_sel,
  input  logic               alpha_en,
  input  logic               is_420,
  input  logic               force_max,
  input  logic [TAP_W-1:0]   vtaps_y,
  input  logic [TAP_W-1:0]   vtaps_c,
  input  logic [RATIO_W-1:0] vratio_y,
  input  logic [RATIO_W-1:0] vratio_c,
  output logic               done,
  output logic [1:0]         cfg,
  output logic [PART_W-1:0]  parts_y,
  output logic [PART_W-1:0]  parts_c
);
  localparam int DW = WIDTH_W + 4;

  state_t             state;
  logic [2:0]         op;
  logic [1:0]         trial;
  logic [WIDTH_W-1:0] wy_q, wc_q;
  logic [1:0]         bsel_q;
  logic               alpha_q, is420_q, force_q;
  logic [TAP_W-1:0]   vt_y_q, vt_c_q;
  logic [RATIO_W-1:0] rc_y_q, rc_c_q;
  logic [DW-1:0]      words_y, words_c, words_a, q_y, q_c, q_a;

  logic          div_start, div_done;
  logic [DW-1:0] div_num, div_den, div_quo;
  logic [1:0]    cfg_cur;
  logic [DW-1:0] py_lim, py_cl, pc_cl;
  logic          fit_y, fit_c, accept;

  function automatic logic fits(input logic [DW-1:0] parts,
                                input logic [RATIO_W-1:0] r,
                                input logic [TAP_W-1:0] t);
    if (r > RATIO_W'(2)) return (DW'(t) + DW'(r)) <= (parts + DW'(2));
    return DW'(t) <= parts;
  endfunction

  assign cfg_cur = trial + 2'd1;

  always_comb begin
    div_num = '0;
    div_den = DW'(1);
    case (op)
      3'd0: begin div_num = DW'(wy_q) * DW'(bpc_bits(bsel_q)) + DW'(WORD_BITS - 1); div_den = DW'(WORD_BITS); end
      3'd1: begin div_num = DW'(wc_q) * DW'(bpc_bits(bsel_q)) + DW'(WORD_BITS - 1); div_den = DW'(WORD_BITS); end
      3'd2: begin div_num = DW'(wy_q) + DW'(ALPHA_PIX - 1); div_den = DW'(ALPHA_PIX); end
      3'd3: begin div_num = DW'(mem_words(cfg_cur, PL_Y)); div_den = words_y; end
      3'd4: begin div_num = DW'(mem_words(cfg_cur, PL_C)); div_den = words_c; end
      default: begin div_num = DW'(mem_words(cfg_cur, PL_A)); div_den = words_a; end
    endcase
  end

  always_comb begin
    py_lim = (alpha_q && (q_a < q_y)) ? q_a : q_y;
    py_cl  = (py_lim > DW'(MAX_PARTS)) ? DW'(MAX_PARTS) : py_lim;
    pc_cl  = (q_c > DW'(MAX_PARTS)) ? DW'(MAX_PARTS) : q_c;
    fit_y  = fits(py_cl, rc_y_q, vt_y_q);
    fit_c  = fits(pc_cl, rc_c_q, vt_c_q);
    accept = force_q || (trial == 2'd3) || (fit_y && fit_c);
  end

  assign div_start = (state == ST_ISSUE);

  lbsel_div #(.DW(DW)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .num(div_num), .den(div_den),
    .done(div_done), .quo(div_quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; op <= '0; trial <= '0;
      wy_q <= '0; wc_q <= '0; bsel_q <= '0;
      alpha_q <= 1'b0; is420_q <= 1'b0; force_q <= 1'b0;
      vt_y_q <= '0; vt_c_q <= '0; rc_y_q <= '0; rc_c_q <= '0;
      words_y <= '0; words_c <= '0; words_a <= '0;
      q_y <= '0; q_c <= '0; q_a <= '0;
      done <= 1'b0; cfg <= '0; parts_y <= '0; parts_c <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          wy_q    <= (width_y == '0) ? WIDTH_W'(1) : width_y;
          wc_q    <= (width_c == '0) ? WIDTH_W'(1) : width_c;
          bsel_q  <= bpc_sel;
          alpha_q <= alpha_en;
          is420_q <= is_420;
          force_q <= force_max;
          vt_y_q  <= vtaps_y;  vt_c_q <= vtaps_c;
          rc_y_q  <= vratio_y; rc_c_q <= vratio_c;
          trial   <= force_max ? (is_420 ? 2'd2 : 2'd3) : 2'd0;
          op      <= 3'd0;
          state   <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: if (div_done) begin
          case (op)
            3'd0: words_y <= div_quo;
            3'd1: words_c <= div_quo;
            3'd2: words_a <= div_quo;
            3'd3: q_y <= div_quo;
            3'd4: q_c <= div_quo;
            default: q_a <= div_quo;
          endcase
          if (op == 3'd5) state <= ST_EVAL;
          else begin op <= op + 3'd1; state <= ST_ISSUE; end
        end
        default: begin
          if (accept) begin
            done    <= 1'b1;
            cfg     <= cfg_cur;
            parts_y <= PART_W'(py_cl);
            parts_c <= PART_W'(pc_cl);
            state   <= ST_IDLE;
          end else begin
            trial <= (trial == 2'd1 && !is420_q) ? 2'd3 : trial + 2'd1;
            op    <= 3'd3;
            state <= ST_ISSUE;
          end
        end
      endcase
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_parts_clamped_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (parts_y <= PART_W'(MAX_PARTS)) && (parts_c <= PART_W'(MAX_PARTS)));
  assert_forced_cfg_R6: assert property (@(posedge clk) disable iff (rst)
    (done && force_q) |-> (cfg == (is420_q ? 2'd3 : 2'd0)));
  assert_cfg3_only_420_R5: assert property (@(posedge clk) disable iff (rst)
    (done && cfg == 2'd3) |-> is420_q);
  assert_accepted_fits_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !force_q && cfg != 2'd0) |->
      (fits(DW'(parts_y), rc_y_q, vt_y_q) && fits(DW'(parts_c), rc_c_q, vt_c_q)));
  assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(cfg) && $stable(parts_y) && $stable(parts_c));
endmodule

// File: tb/tb_lb_cfg_select.sv
module tb_lb_cfg_select;
  localparam int WIDTH_W = 14;
  localparam int PART_W  = 7;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [WIDTH_W-1:0] width_y = '0, width_c = '0;
  logic [1:0] bpc_sel = '0;
  logic alpha_en = 1'b0, is_420 = 1'b0, force_max = 1'b0;
  logic [3:0] vtaps_y = '0, vtaps_c = '0, vratio_y = '0, vratio_c = '0;
  logic done;
  logic [1:0] cfg;
  logic [PART_W-1:0] parts_y, parts_c;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  lb_cfg_select dut (
    .clk(clk), .rst(rst), .start(start), .width_y(width_y), .width_c(width_c),
    .bpc_sel(bpc_sel), .alpha_en(alpha_en), .is_420(is_420), .force_max(force_max),
    .vtaps_y(vtaps_y), .vtaps_c(vtaps_c), .vratio_y(vratio_y), .vratio_c(vratio_c),
    .done(done), .cfg(cfg), .parts_y(parts_y), .parts_c(parts_c)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sz(input int c, input int pl);
    if (pl == 2) return (c == 1) ? 984 : (c == 2) ? 1312 : 2752;
    if (c == 1) return 816;
    if (c == 2) return 1088;
    if (c == 3) return (pl == 0) ? 4448 : 1904;
    return 2752;
  endfunction

  function automatic bit ok(input int p, input int r, input int t);
    return (r > 2) ? (t <= p - r + 2) : (t <= p);
  endfunction

  task automatic model(input int wy, input int wc, input int bs, input int al,
                       input int f4, input int fm, input int ty, input int tc,
                       input int ry, input int rc,
                       output int ec, output int epy, output int epc);
    int b, ly, lc, la, pa;
    int order[4];
    b = (bs == 0) ? 10 : (bs == 1) ? 8 : (bs == 2) ? 6 : 12;
    if (wy == 0) wy = 1;
    if (wc == 0) wc = 1;
    ly = (wy * b + 71) / 72;
    lc = (wc * b + 71) / 72;
    la = (wy + 5) / 6;
    order = '{1, 2, 3, 0};
    ec = 0;
    for (int i = 0; i < 4; i++) begin
      int c;
      c = order[i];
      if (fm != 0 && c != (f4 != 0 ? 3 : 0)) continue;
      if (c == 3 && f4 == 0) continue;
      epy = sz(c, 0) / ly;
      epc = sz(c, 1) / lc;
      pa = sz(c, 2) / la;
      if (al != 0 && pa < epy) epy = pa;
      if (epy > 64) epy = 64;
      if (epc > 64) epc = 64;
      ec = c;
      if (fm != 0 || c == 0 || (ok(epy, ry, ty) && ok(epc, rc, tc))) break;
    end
  endtask

  task automatic wait_done(input string tag, output bit got);
    got = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
    if (!got) check({tag, " watchdog"}, 0, 1);
  endtask

  task automatic run(input string tag, input int wy, input int wc, input int bs,
                     input int al, input int f4, input int fm, input int ty,
                     input int tc, input int ry, input int rc,
                     output int oc, output int opy, output int opc);
    int ec, epy, epc;
    bit got;
    @(negedge clk);
    width_y = WIDTH_W'(wy); width_c = WIDTH_W'(wc); bpc_sel = 2'(bs);
    alpha_en = al[0]; is_420 = f4[0]; force_max = fm[0];
    vtaps_y = 4'(ty); vtaps_c = 4'(tc); vratio_y = 4'(ry); vratio_c = 4'(rc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(tag, got);
    model(wy, wc, bs, al, f4, fm, ty, tc, ry, rc, ec, epy, epc);
    oc = cfg; opy = parts_y; opc = parts_c;
    if (got) begin
      check({tag, " cfg"}, cfg, ec);
      check({tag, " parts_y"}, parts_y, epy);
      check({tag, " parts_c"}, parts_c, epc);
    end
  endtask

  task automatic t_reset;
    check("R8 done", done, 0);
    check("R8 cfg", cfg, 0);
    check("R8 parts_y", parts_y, 0);
    check("R8 parts_c", parts_c, 0);
  endtask

  task automatic t_words;
    int c0, y0, p0, c1, y1, p1;
    run("R1 hd 8bit", 1920, 960, 1, 0, 0, 0, 4, 2, 1, 1, c0, y0, p0);
    check("R1 hd 8bit cfg2", c0, 2);
    check("R1 hd 8bit luma", y0, 5);
    run("R1 zero width", 0, 0, 3, 0, 0, 0, 2, 2, 1, 1, c0, y0, p0);
    run("R1 unit width", 1, 1, 3, 0, 0, 0, 2, 2, 1, 1, c1, y1, p1);
    check("R1 zero equals one", y0, y1);
    check("R2 clamp 64", y0, 64);
    run("R1 10bit", 3000, 1500, 0, 0, 0, 0, 3, 3, 2, 2, c0, y0, p0);
  endtask

  task automatic t_alpha;
    int c, y, p;
    run("R3 alpha on", 100, 50, 2, 1, 0, 0, 2, 2, 1, 1, c, y, p);
    check("R3 alpha limit", y, 57);
    run("R3 alpha off", 100, 50, 2, 0, 0, 0, 2, 2, 1, 1, c, y, p);
    check("R3 no alpha limit", y, 64);
  endtask

  task automatic t_ratio;
    int c, y, p;
    run("R4 ratio 4", 1920, 960, 1, 0, 0, 0, 4, 2, 4, 1, c, y, p);
    check("R4 ratio pushes past cfg2", c, 0);
    run("R4 ratio 2", 1920, 960, 1, 0, 0, 0, 4, 2, 2, 1, c, y, p);
    check("R4 ratio 2 cfg2", c, 2);
  endtask

  task automatic t_order;
    int c, y, p;
    run("R5 wide 420", 8000, 4000, 3, 0, 1, 0, 2, 2, 1, 1, c, y, p);
    check("R5 picks cfg3", c, 3);
    run("R5 wide 444", 8000, 4000, 3, 0, 0, 0, 2, 2, 1, 1, c, y, p);
    check("R5 fallback cfg0", c, 0);
    run("R5 small", 640, 320, 1, 0, 0, 0, 2, 2, 1, 1, c, y, p);
    check("R5 first cfg1", c, 1);
  endtask

  task automatic t_force;
    int c, y, p;
    run("R6 force 420", 640, 320, 1, 0, 1, 1, 2, 2, 1, 1, c, y, p);
    check("R6 forced cfg3", c, 3);
    run("R6 force 444", 640, 320, 1, 0, 0, 1, 2, 2, 1, 1, c, y, p);
    check("R6 forced cfg0", c, 0);
  endtask

  task automatic t_busy;
    int ec, epy, epc, dcount;
    bit got;
    @(negedge clk);
    width_y = 14'd640; width_c = 14'd320; bpc_sel = 2'd1; alpha_en = 1'b0;
    is_420 = 1'b0; force_max = 1'b0; vtaps_y = 4'd2; vtaps_c = 4'd2;
    vratio_y = 4'd1; vratio_c = 4'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    width_y = 14'd8000; width_c = 14'd4000; bpc_sel = 2'd3; force_max = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R7 busy", got);
    model(640, 320, 1, 0, 0, 0, 2, 2, 1, 1, ec, epy, epc);
    check("R7 busy start ignored cfg", cfg, ec);
    check("R7 busy start ignored parts_y", parts_y, epy);
    dcount = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (done) dcount++;
    end
    check("R7 single done", dcount, 0);
    check("R7 outputs hold", parts_y, epy);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_words();
    t_alpha();
    t_ratio();
    t_order();
    t_force();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule